// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects five external interrupt lines and presents one interrupt request to a processor. A rising edge on a line latches a bit in a pending register. A mask register selects which pending bits may take part in arbitration. An execution register records which handlers are running, including handlers that have been preempted. The request is raised only when the best unmasked pending line outranks every handler recorded as running. Line 4 has the highest priority and line 0 the lowest.

The processor reaches the block over a simple register bus with an address, a write enable, write data and combinational read data. An acknowledge strobe, which carries the accepted line number, moves that line from pending to executing. A return strobe retires the innermost handler. Separate set and clear alias addresses for the pending and execution registers let software change single bits without a read-modify-write sequence.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending, mask and execution registers all read zero and `cpu_req` is low.
- R2: A low-to-high transition on `irq_in[i]` sets pending bit i at the next clock edge. A line that is held high does not set the bit again after it is cleared.
- R3: Offset 0x080 reads and writes the pending register, offset 0x0C0 the mask register and offset 0x100 the execution register. Bit i of each register belongs to line i, for i from 0 to 4.
- R4: A write to offset 0x084 sets each pending bit whose write-data bit is 1. A write to offset 0x088 clears each pending bit whose write-data bit is 1. Write-data bits that are 0 change nothing.
- R5: Offsets 0x104 and 0x108 set and clear execution bits in the same way as the pending aliases.
- R6: A pending bit whose mask bit is 0 stays latched but cannot cause a request.
- R7: `cpu_req` is high exactly when the highest unmasked pending line is strictly above the highest set execution bit, or when no execution bit is set. `cpu_req_id` then gives that pending line.
- R8: When `cpu_ack` is high, the pending bit of `cpu_ack_id` is cleared and its execution bit is set at the same clock edge.
- R9: When `cpu_ret` is high, only the highest set execution bit is cleared. Lower set bits stay set.
- R10: If a rising edge on a line and a software clear of the same pending bit fall in one cycle, the pending bit ends up set.
- R11: Bits 31 to 5 of `bus_rdata` always read zero. Unmapped offsets and the four alias offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 5 | External interrupt lines, synchronous to clk |
| bus_addr | input | 9 | Register byte offset |
| bus_we | input | 1 | Write enable for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_req_id | output | 3 | Line number of the request |
| cpu_ack | input | 1 | Processor accepts a line |
| cpu_ack_id | input | 3 | Line number being accepted |
| cpu_ret | input | 1 | Processor returns from the current handler |

## Verification
The embedded properties check on every cycle that a raised request names a line that is both pending and unmasked, and that no running handler sits at or above it. They also check that an acknowledge retires the pending bit, that a return drops exactly one execution bit, that a hardware-set bit always survives the edge, and that unused read bits stay zero. Only the bench scenarios show the decoding of each offset, the ignored zero bits in alias writes, and the strict comparison when a pending line equals the running level. The scenarios also cover a full nest of acknowledges and returns, and the collision between an edge and a software clear.

// File: rtl/nic_pkg.sv
// Package: shared register offsets for the nested interrupt controller.
// Assumes a 9-bit byte-offset bus; offsets are fixed by software convention.
package nic_pkg;
    localparam int unsigned ADDR_W = 9;

    localparam logic [ADDR_W-1:0] OFS_PEND     = 9'h080;
    localparam logic [ADDR_W-1:0] OFS_PEND_SET = 9'h084;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 9'h088;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 9'h0C0;
    localparam logic [ADDR_W-1:0] OFS_EXEC     = 9'h100;
    localparam logic [ADDR_W-1:0] OFS_EXEC_SET = 9'h104;
    localparam logic [ADDR_W-1:0] OFS_EXEC_CLR = 9'h108;
endpackage

// File: rtl/nic_edge.sv
// Module: nic_edge
// Detects low-to-high transitions on each interrupt line.
// Assumes the lines are already synchronous to clk; a transition yields a
// one-cycle pulse in the cycle where the new high level is first seen.
module nic_edge #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // A line that is high now and was low before has risen.
    always_comb rise = lines & ~prev_q;
endmodule

// File: rtl/nic_prio.sv
// Module: nic_prio
// Priority encoder: reports whether any bit is set and the index of the
// highest set bit. Higher index means higher priority.
module nic_prio #(
    parameter int unsigned N    = 5,
    parameter int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    vec,
    output logic            valid,
    output logic [ID_W-1:0] idx
);
    // Scan upward so the last hit is the highest index.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end

    // Encoder output agrees with its input vector.
    always_comb begin
        if (valid) assert (vec[idx]) else $error("a_r7_prio_hit");
        assert (valid == (|vec)) else $error("a_r7_prio_valid");
    end
endmodule

// File: rtl/nic_bitreg.sv
// Module: nic_bitreg
// An N-bit register with a direct write, write-one-to-set and
// write-one-to-clear ports, a hardware clear and a hardware set.
// The update is applied in that order, so the hardware set has the last word.
module nic_bitreg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_clr,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] q
);
    logic [N-1:0] nxt;

    // Next value: write, then software set/clear, then hardware clear/set.
    always_comb begin
        nxt = wr_en ? wr_val : q;
        nxt = (nxt | sw_set) & ~sw_clr;
        nxt = (nxt & ~hw_clr) | hw_set;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // Hardware-set bits always read back set (R2, R8, R10).
    a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/nested_irq_ctrl.sv
// Module: nested_irq_ctrl
// Five-line nested priority interrupt controller. Holds the pending, mask and
// execution registers and requests the processor only above the running level.
// Assumes: irq_in is synchronous to clk; cpu_ack_id names the currently
// requested line; cpu_ret is pulsed once per handler exit.
module nested_irq_ctrl #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned ID_W   = $clog2(NUM_SRC),
    localparam int unsigned AW     = nic_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_req,
    output logic [ID_W-1:0]   cpu_req_id,
    input  logic              cpu_ack,
    input  logic [ID_W-1:0]   cpu_ack_id,
    input  logic              cpu_ret
);
    import nic_pkg::*;

    logic [NUM_SRC-1:0] wd, rise, pend_q, mask_q, exec_q;
    logic [NUM_SRC-1:0] ack_vec, ret_vec, zero_vec;
    logic               wr_pend, set_pend, clr_pend, wr_mask;
    logic               wr_exec, set_exec, clr_exec;
    logic               pv, ev;
    logic [ID_W-1:0]    pidx, eidx;

    // Low write-data bits map one per line.
    always_comb wd = bus_wdata[NUM_SRC-1:0];
    always_comb zero_vec = '0;

    // Decode write strobes per offset.
    always_comb begin
        wr_pend  = bus_we && (bus_addr == OFS_PEND);
        set_pend = bus_we && (bus_addr == OFS_PEND_SET);
        clr_pend = bus_we && (bus_addr == OFS_PEND_CLR);
        wr_mask  = bus_we && (bus_addr == OFS_MASK);
        wr_exec  = bus_we && (bus_addr == OFS_EXEC);
        set_exec = bus_we && (bus_addr == OFS_EXEC_SET);
        clr_exec = bus_we && (bus_addr == OFS_EXEC_CLR);
    end

    // One-hot vectors for the acknowledged line and the innermost handler.
    always_comb begin
        ack_vec = cpu_ack ? (NUM_SRC'(1) << cpu_ack_id) : '0;
        ret_vec = (cpu_ret && ev) ? (NUM_SRC'(1) << eidx) : '0;
    end

    nic_edge #(.N(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .rise(rise)
    );

    nic_bitreg #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_pend), .wr_val(wd),
        .sw_set(set_pend ? wd : zero_vec), .sw_clr(clr_pend ? wd : zero_vec),
        .hw_clr(ack_vec), .hw_set(rise),
        .q(pend_q)
    );

    nic_bitreg #(.N(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_mask), .wr_val(wd),
        .sw_set(zero_vec), .sw_clr(zero_vec),
        .hw_clr(zero_vec), .hw_set(zero_vec),
        .q(mask_q)
    );

    nic_bitreg #(.N(NUM_SRC)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_exec), .wr_val(wd),
        .sw_set(set_exec ? wd : zero_vec), .sw_clr(clr_exec ? wd : zero_vec),
        .hw_clr(ret_vec), .hw_set(ack_vec),
        .q(exec_q)
    );

    nic_prio #(.N(NUM_SRC), .ID_W(ID_W)) u_pprio (
        .vec(pend_q & mask_q), .valid(pv), .idx(pidx)
    );

    nic_prio #(.N(NUM_SRC), .ID_W(ID_W)) u_eprio (
        .vec(exec_q), .valid(ev), .idx(eidx)
    );

    // Request only strictly above the running level.
    always_comb begin
        cpu_req    = pv && (!ev || (pidx > eidx));
        cpu_req_id = cpu_req ? pidx : '0;
    end

    // Read multiplexer: mapped registers only, all else zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_PEND: bus_rdata[NUM_SRC-1:0] = pend_q;
            OFS_MASK: bus_rdata[NUM_SRC-1:0] = mask_q;
            OFS_EXEC: bus_rdata[NUM_SRC-1:0] = exec_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R7: nothing running at or above the requested line.
    a_r7_req_above_active: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ((exec_q >> cpu_req_id) == '0));

    // R6: requested line is pending and unmasked.
    a_r6_req_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (mask_q[cpu_req_id] && pend_q[cpu_req_id]));

    // R9: an undisturbed return drops exactly one execution bit.
    a_r9_ret_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && (exec_q != '0) && !cpu_ack && !bus_we) |=>
        ($countones(exec_q) == $countones($past(exec_q)) - 1));

    // R8: an acknowledge retires the pending bit unless a new edge arrives.
    a_r8_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && (32'(cpu_ack_id) < NUM_SRC) && !rise[cpu_ack_id] && !bus_we) |=>
        (!pend_q[$past(cpu_ack_id)] && exec_q[$past(cpu_ack_id)]));

    // R11: unused read bits stay zero.
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/nested_irq_ctrl_tb.sv
// Bench: scoreboard. Driver tasks push expected items; a monitor pops and
// compares them against the design's outputs.
module nested_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_in = '0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_req;
    logic [2:0]  cpu_req_id;
    logic        cpu_ack = 1'b0;
    logic [2:0]  cpu_ack_id = '0;
    logic        cpu_ret = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;   // 0: read data, 1: {req, id}
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event go, done;

    always #5 clk = ~clk;

    nested_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_req(cpu_req), .cpu_req_id(cpu_req_id),
        .cpu_ack(cpu_ack), .cpu_ack_id(cpu_ack_id), .cpu_ret(cpu_ret)
    );

    // Monitor: pop expected items and compare with live outputs.
    initial begin
        forever begin
            @(go);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? bus_rdata : {28'd0, cpu_req, cpu_req_id};
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
            -> done;
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> go;
        @(done);
    endtask

    task automatic rd(logic [8:0] a, logic [31:0] exp, string tag);
        bus_we = 1'b0; bus_addr = a;
        push(0, exp, tag);
    endtask

    task automatic req(logic r, logic [2:0] id, string tag);
        push(1, {28'd0, r, id}, tag);
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ack(logic [2:0] id);
        @(negedge clk);
        cpu_ack = 1'b1; cpu_ack_id = id;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic iret();
        @(negedge clk);
        cpu_ret = 1'b1;
        @(negedge clk);
        cpu_ret = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(9'h080, 32'h0, "R1 pending");
        rd(9'h0C0, 32'h0, "R1 mask");
        rd(9'h100, 32'h0, "R1 exec");
        req(1'b0, 3'd0, "R1 req");

        wr(9'h0C0, 32'hFFFF_FFFF);
        rd(9'h0C0, 32'h1F, "R11 mask upper bits");
        wr(9'h0C0, 32'h1F);
        rd(9'h0C0, 32'h1F, "R3 mask");

        @(negedge clk); irq_in[1] = 1'b1;
        @(negedge clk);
        rd(9'h080, 32'h02, "R2 edge sets");
        req(1'b1, 3'd1, "R7 single");
        wr(9'h088, 32'h02);
        rd(9'h080, 32'h00, "R4 clear alias");
        @(negedge clk);
        rd(9'h080, 32'h00, "R2 level no reset");
        irq_in = '0;

        wr(9'h084, 32'h05);
        rd(9'h080, 32'h05, "R4 set alias");
        wr(9'h084, 32'h00);
        rd(9'h080, 32'h05, "R4 zero ignored");
        req(1'b1, 3'd2, "R7 highest");
        wr(9'h088, 32'h01);
        rd(9'h080, 32'h04, "R4 clear one");

        wr(9'h0C0, 32'h1B);
        req(1'b0, 3'd0, "R6 masked no req");
        rd(9'h080, 32'h04, "R6 stays latched");
        wr(9'h0C0, 32'h1F);
        req(1'b1, 3'd2, "R6 unmasked");

        ack(3'd2);
        rd(9'h080, 32'h00, "R8 pending cleared");
        rd(9'h100, 32'h04, "R8 exec set");
        req(1'b0, 3'd0, "R8 no req");

        wr(9'h084, 32'h02);
        req(1'b0, 3'd0, "R7 below active");
        wr(9'h084, 32'h08);
        req(1'b1, 3'd3, "R7 preempt");
        ack(3'd3);
        rd(9'h100, 32'h0C, "R8 nested exec");
        rd(9'h080, 32'h02, "R8 nested pending");
        iret();
        rd(9'h100, 32'h04, "R9 ret top only");
        req(1'b0, 3'd0, "R9 still blocked");
        iret();
        rd(9'h100, 32'h00, "R9 ret last");
        req(1'b1, 3'd1, "R9 released");
        ack(3'd1);
        rd(9'h100, 32'h02, "R8 exec one");

        wr(9'h104, 32'h11);
        rd(9'h100, 32'h13, "R5 exec set alias");
        wr(9'h108, 32'h02);
        rd(9'h100, 32'h11, "R5 exec clear alias");
        wr(9'h100, 32'h08);
        rd(9'h100, 32'h08, "R3 exec direct");
        wr(9'h084, 32'h08);
        req(1'b0, 3'd0, "R7 equal level");
        iret();
        req(1'b1, 3'd3, "R7 after ret");
        wr(9'h080, 32'h00);
        rd(9'h080, 32'h00, "R3 pending direct");

        @(negedge clk);
        irq_in[0] = 1'b1;
        bus_addr = 9'h088; bus_wdata = 32'h01; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(9'h080, 32'h01, "R10 hw set wins");
        req(1'b1, 3'd0, "R10 req");

        wr(9'h080, 32'hFF);
        rd(9'h080, 32'h1F, "R11 pending upper bits");
        rd(9'h090, 32'h0, "R11 unmapped");
        rd(9'h084, 32'h0, "R11 alias read");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule